// File: doc/BRIEF.md
# Memory protection checker with bus-fault recorder

The block judges every CPU memory access against the privilege level of the requester and the attribute bits of the page map entry that belongs to the addressed page. A supervisor access always passes. A user access goes through four checks in a fixed order, and the first check that fails decides the result. On a fault the block raises a one-cycle bus error toward the CPU and records diagnostic state in three read-only 16-bit registers: a general status word, a bus status word that holds the access lane and the upper address byte, and a bus status word that holds the lower address half.

The caller presents one request per cycle with `req_valid_i`. The verdict, the fault cause and the bus error pulse appear one clock later. The recorded registers keep their contents until the next fault or reset. Address translation and exception handling stay outside the block.

Top module: `mpr_access_guard`

## Requirements
- R1: A request with `super_i` high is allowed (`allow_o`=1, `cause_o`=0). It raises no bus error and leaves all three status registers unchanged.
- R2: A user request with address at or above 0x400000 faults with `cause_o`=1 and loads the general status register with 0x9EFF.
- R3: A user request whose map entry bits 14 and 13 are both zero (page absent) faults with `cause_o`=2 and loads the general status register with 0x8FFF.
- R4: A user request with address bits 22..19 all zero (kernel region) faults with `cause_o`=3 and leaves the general status register unchanged.
- R5: A user write whose map entry bit 15 is clear faults with `cause_o`=4 and leaves the general status register unchanged. A user read is not affected by bit 15.
- R6: When several checks fail, the reported cause is the first one in this order: range (1), absent (2), kernel (3), write protect (4).
- R7: On any fault, bus status 0 gets high byte 0x7F for `size_i` 1 (16-bit) or 2 (32-bit). For `size_i` 0 (8-bit) it gets 0x7D at an odd address and 0x7E at an even address. Its low byte gets address bits 23..16.
- R8: On any fault, bus status 1 gets address bits 15..0.
- R9: `resp_valid_o`, `allow_o`, `cause_o` and `bus_err_o` refer to the request sampled at the previous clock edge. `bus_err_o` is high for exactly the cycle that reports a faulting request and low otherwise. Between faults the status registers hold.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request present this cycle |
| addr_i | input | 24 | Access byte address |
| size_i | input | 2 | Access width: 0 byte, 1 word, 2 long |
| write_i | input | 1 | 1 write, 0 read |
| super_i | input | 1 | Requester runs in supervisor mode |
| map_entry_i | input | 16 | Map entry of the addressed page |
| resp_valid_o | output | 1 | Verdict for previous request valid |
| allow_o | output | 1 | Access allowed |
| cause_o | output | 3 | Fault cause, 0 when allowed |
| bus_err_o | output | 1 | One-cycle bus error pulse |
| gen_stat_o | output | 16 | General status register |
| bus_stat0_o | output | 16 | Lane code and address bits 23..16 of last fault |
| bus_stat1_o | output | 16 | Address bits 15..0 of last fault |

## Verification
On every cycle the assertions check four things. Supervisor requests come back allowed. A bus error appears only one cycle after a request. Kernel and write-protect faults leave the general status unchanged. The bus status registers stay stable when no bus error occurs. The priority order between overlapping violations, the exact lane codes for each width and byte offset, and the captured address fields show up only in the bench's scenarios. In those scenarios a model scores each response against the request that caused it, including back-to-back faults and random traffic.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_RANGE  = 3'd1,
    CAUSE_ABSENT = 3'd2,
    CAUSE_KERNEL = 3'd3,
    CAUSE_WPROT  = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  localparam int unsigned NUM_RULES = 4;

  // map entry attribute bits
  localparam int unsigned ENT_WE      = 15;
  localparam int unsigned ENT_PRES_HI = 14;
  localparam int unsigned ENT_PRES_LO = 13;

  localparam logic [15:0] GS_RANGE  = 16'h9EFF;
  localparam logic [15:0] GS_ABSENT = 16'h8FFF;

  localparam logic [7:0] LANE_WIDE = 8'h7F;
  localparam logic [7:0] LANE_ODD  = 8'h7D;
  localparam logic [7:0] LANE_EVEN = 8'h7E;
endpackage

// File: rtl/mpr_rule_chain.sv
module mpr_rule_chain
  import mpr_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 24,
  parameter logic [ADDR_W-1:0]    RAM_LIMIT = 24'h400000,
  parameter int unsigned          KRN_HI    = 22,
  parameter int unsigned          KRN_LO    = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              super_i,
  input  logic [15:0]       entry_i,
  output cause_e            cause_o
);
  logic [NUM_RULES-1:0] fail;
  logic [2:0]           pick;

  // index order is check priority, 0 first
  assign fail[0] = addr_i >= RAM_LIMIT;
  assign fail[1] = entry_i[ENT_PRES_HI:ENT_PRES_LO] == 2'b00;
  assign fail[2] = addr_i[KRN_HI:KRN_LO] == '0;
  assign fail[3] = write_i && !entry_i[ENT_WE];

  always_comb begin
    pick = 3'd0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (fail[i]) pick = 3'(i + 1);
    end
    cause_o = super_i ? CAUSE_NONE : cause_e'(pick);
  end
endmodule

// File: rtl/mpr_lane_code.sv
module mpr_lane_code
  import mpr_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic       addr_lsb_i,
  output logic [7:0] lane_o
);
  always_comb begin
    if (size_i != SZ_BYTE) lane_o = LANE_WIDE;
    else if (addr_lsb_i)   lane_o = LANE_ODD;
    else                   lane_o = LANE_EVEN;
  end
endmodule

// File: rtl/mpr_fault_regs.sv
module mpr_fault_regs
  import mpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  cause_e            cause_i,
  input  logic [7:0]        lane_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REG_W-1:0]  gen_stat_o,
  output logic [REG_W-1:0]  bus_stat0_o,
  output logic [REG_W-1:0]  bus_stat1_o
);
  localparam int unsigned SEG_W = ADDR_W - REG_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_stat_o  <= '0;
      bus_stat0_o <= '0;
      bus_stat1_o <= '0;
    end else if (load_i) begin
      bus_stat0_o <= REG_W'({lane_i, addr_i[ADDR_W-1 -: SEG_W]});
      bus_stat1_o <= addr_i[REG_W-1:0];
      if (cause_i == CAUSE_RANGE)       gen_stat_o <= GS_RANGE;
      else if (cause_i == CAUSE_ABSENT) gen_stat_o <= GS_ABSENT;
    end
  end

  a_r8_bs1_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bus_stat1_o));
  a_r9_bs0_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bus_stat0_o));
endmodule

// File: rtl/mpr_access_guard.sv
module mpr_access_guard
  import mpr_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       REG_W     = 16,
  parameter logic [ADDR_W-1:0] RAM_LIMIT = 24'h400000,
  parameter int unsigned       KRN_HI    = 22,
  parameter int unsigned       KRN_LO    = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  input  logic              super_i,
  input  logic [15:0]       map_entry_i,
  output logic              resp_valid_o,
  output logic              allow_o,
  output logic [2:0]        cause_o,
  output logic              bus_err_o,
  output logic [REG_W-1:0]  gen_stat_o,
  output logic [REG_W-1:0]  bus_stat0_o,
  output logic [REG_W-1:0]  bus_stat1_o
);
  cause_e     cause_c;
  logic [7:0] lane_c;
  logic       fault_c;

  mpr_rule_chain #(
    .ADDR_W(ADDR_W), .RAM_LIMIT(RAM_LIMIT), .KRN_HI(KRN_HI), .KRN_LO(KRN_LO)
  ) u_rules (
    .addr_i (addr_i),
    .write_i(write_i),
    .super_i(super_i),
    .entry_i(map_entry_i),
    .cause_o(cause_c)
  );

  mpr_lane_code u_lane (
    .size_i    (size_i),
    .addr_lsb_i(addr_i[0]),
    .lane_o    (lane_c)
  );

  assign fault_c = req_valid_i && (cause_c != CAUSE_NONE);

  mpr_fault_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fault_c),
    .cause_i    (cause_c),
    .lane_i     (lane_c),
    .addr_i     (addr_i),
    .gen_stat_o (gen_stat_o),
    .bus_stat0_o(bus_stat0_o),
    .bus_stat1_o(bus_stat1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      allow_o      <= 1'b0;
      cause_o      <= '0;
      bus_err_o    <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      allow_o      <= req_valid_i && (cause_c == CAUSE_NONE);
      cause_o      <= req_valid_i ? cause_c : CAUSE_NONE;
      bus_err_o    <= fault_c;
    end
  end

  a_r1_super_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && super_i |=> allow_o && !bus_err_o);
  a_r9_err_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !bus_err_o && !resp_valid_o);
  a_r4_kernel_keeps_gs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o && (cause_o == CAUSE_KERNEL) |-> $stable(gen_stat_o));
  a_r5_wprot_keeps_gs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o && (cause_o == CAUSE_WPROT) |-> $stable(gen_stat_o));
  a_r9_err_matches_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> resp_valid_o && !allow_o);
endmodule

// File: tb/mpr_access_guard_tb_top.sv
module mpr_access_guard_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic        allow;
    logic [2:0]  cause;
    logic [15:0] gs;
    logic [15:0] bs0;
    logic [15:0] bs1;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0;
  logic        sup = 1'b0;
  logic [15:0] entry = '0;
  logic        resp_valid, allow, bus_err;
  logic [2:0]  cause;
  logic [15:0] gs, bs0, bs1;

  int n_checks = 0;
  int n_fail = 0;
  exp_t q[$];
  logic [15:0] m_gs = '0, m_bs0 = '0, m_bs1 = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpr_access_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .addr_i(addr),
    .size_i(size), .write_i(wr), .super_i(sup), .map_entry_i(entry),
    .resp_valid_o(resp_valid), .allow_o(allow), .cause_o(cause),
    .bus_err_o(bus_err), .gen_stat_o(gs), .bus_stat0_o(bs0), .bus_stat1_o(bs1)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // model of the requirements: cause priority R2..R6, lanes R7, address R8
  task automatic drive(logic [23:0] a, logic [1:0] s, logic w, logic su,
                       logic [15:0] e, string tag);
    exp_t x;
    logic [2:0] c;
    @(negedge clk);
    c = 3'd0;
    if (!su) begin
      if (a >= 24'h400000)         c = 3'd1;
      else if (e[14:13] == 2'b00)  c = 3'd2;
      else if (a[22:19] == 4'd0)   c = 3'd3;
      else if (w && !e[15])        c = 3'd4;
    end
    if (c != 3'd0) begin
      if (c == 3'd1) m_gs = 16'h9EFF;
      if (c == 3'd2) m_gs = 16'h8FFF;
      m_bs0 = {(s != 2'd0) ? 8'h7F : (a[0] ? 8'h7D : 8'h7E), a[23:16]};
      m_bs1 = a[15:0];
    end
    x.allow = (c == 3'd0); x.cause = c; x.gs = m_gs; x.bs0 = m_bs0;
    x.bs1 = m_bs1; x.tag = tag;
    q.push_back(x);
    req_valid = 1'b1; addr = a; size = s; wr = w; sup = su; entry = e;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid) begin
        if (q.size() == 0) begin
          check("R9 unexpected response", 1, 0);
        end else begin
          exp_t x;
          x = q.pop_front();
          check({x.tag, " allow"}, 32'(allow), 32'(x.allow));
          check({x.tag, " cause"}, 32'(cause), 32'(x.cause));
          check({"R9 bus_err ", x.tag}, 32'(bus_err), 32'(!x.allow));
          check({x.tag, " gen_stat"}, 32'(gs), 32'(x.gs));
          check({"R7 bus_stat0 ", x.tag}, 32'(bs0), 32'(x.bs0));
          check({"R8 bus_stat1 ", x.tag}, 32'(bs1), 32'(x.bs1));
        end
      end else if (bus_err) begin
        check("R9 bus_err without response", 32'(bus_err), 0);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 resp_valid", 32'(resp_valid), 0);
    check("R10 allow", 32'(allow), 0);
    check("R10 bus_err", 32'(bus_err), 0);
    check("R10 regs", {gs, bs0}, 0);
    check("R10 bs1", 32'(bs1), 0);
    rst_n = 1'b1;
    idle(2);
    // R1 supervisor: high address, absent page, kernel region
    drive(24'hE43000, 2'd1, 1'b1, 1'b1, 16'h0000, "R1 super high");
    drive(24'h000100, 2'd0, 1'b1, 1'b1, 16'h0000, "R1 super kernel");
    // R2 range, byte odd
    drive(24'h812345, 2'd0, 1'b0, 1'b0, 16'hE000, "R2 range odd");
    // R3 absent, word write
    drive(24'h1A2B3C, 2'd1, 1'b1, 1'b0, 16'h8000, "R3 absent");
    // R4 kernel, byte even
    drive(24'h040102, 2'd0, 1'b0, 1'b0, 16'hE000, "R4 kernel");
    idle(1);
    // R5 write protect, long; read is fine
    drive(24'h0A0010, 2'd2, 1'b1, 1'b0, 16'h6000, "R5 wprot write");
    drive(24'h0A0011, 2'd0, 1'b0, 1'b0, 16'h2000, "R5 wprot read ok");
    drive(24'h0F8000, 2'd1, 1'b1, 1'b0, 16'hC000, "R5 write ok");
    // R6 priority overlaps
    drive(24'h400000, 2'd1, 1'b1, 1'b0, 16'h0000, "R6 range over absent");
    drive(24'h000000, 2'd1, 1'b1, 1'b0, 16'h0000, "R6 absent over kernel");
    drive(24'h07FFFF, 2'd0, 1'b1, 1'b0, 16'h4000, "R6 kernel over wprot");
    drive(24'h3FFFFF, 2'd0, 1'b1, 1'b0, 16'h6000, "R6 wprot at top");
    idle(3);
    // random traffic
    for (int i = 0; i < 300; i++) begin
      logic [23:0] ra;
      ra = 24'($urandom);
      if (i % 2 == 0) ra[23] = 1'b0;
      drive(ra, 2'($urandom_range(0, 2)), 1'($urandom), ($urandom_range(0, 7) == 0),
            16'($urandom), "R6 random");
      if (i % 17 == 0) idle(1);
    end
    idle(3);
    check("R9 queue drained", 32'(q.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule